// File: doc/BRIEF.md
# Bus Wait-State Sequencer

This block times external bus accesses. A start pulse launches an access of one or more beats. The block holds a strobe high for the whole data phase and pulses a per-beat ready flag on the last clock of each beat. It raises a done flag for one clock after the final beat. Every beat lasts one base clock plus a number of wait clocks. That wait count comes from a 4-bit wait code, which sits in a small configuration register, and from the selected interface style.

There are two interface styles. In the plain static-memory style, the code maps to a single wait count that is used for every beat. This map is linear up to nine and grows in larger steps above nine. In the multiplexed address/data style, the two low code bits set the wait count for the first beat, and a read and a write may differ there. Code bit 2 sets the wait count for each later beat. Code bit 3 has no meaning in this style.

There is no data stream, so there is no valid/ready handshake. The start input works as a plain request. It is taken only while the block is idle, which means strobe and done are both low. It is ignored at any other time, with no back-pressure and no queueing. The configuration write port is also plain: a write takes effect at the clock edge where `cfg_we` is high.

Top module: `bus_wait_seq`

## Requirements
- R1: After reset, `strobe`, `beat_rdy` and `done` are low. The wait-code register holds 4'b1111, so an access started without any configuration write waits 25 clocks per beat.
- R2: In static-memory style (`mux_sel`=0), codes 0 to 9 insert exactly that many wait clocks. A beat therefore holds `strobe` high for code+1 clocks, and `beat_rdy` is high only in the last of those clocks.
- R3: In static-memory style, codes 10, 11, 12, 13, 14 and 15 insert 11, 13, 15, 17, 21 and 25 wait clocks.
- R4: In static-memory style, every beat of an access uses the same wait count.
- R5: In multiplexed style (`mux_sel`=1), code bits [1:0] set the first-beat waits. 2'b00 gives 1 wait on a read (`rd_req`=1) and 0 on a write. 2'b01, 2'b10 and 2'b11 give 1, 2 and 3 waits for both reads and writes.
- R6: In multiplexed style, code bit 2 sets the waits of the second and every later beat: 0 gives no wait and 1 gives one wait.
- R7: In multiplexed style, code bit 3 has no effect on any beat length.
- R8: The wait code, style, direction and beat count are captured at the edge that accepts a start. A configuration write in the same edge or during the access does not change that access, and the new code applies from the next access.
- R9: `done` is high for exactly one clock. That clock directly follows the clock in which the last beat's `beat_rdy` is high, and `strobe` is low while `done` is high.
- R10: A start seen while `strobe` or `done` is high is ignored. The running access keeps its length, and no new access follows it.
- R11: A beat count of 0 performs a single beat.
- R12: An accepted start raises `strobe` in the next clock. `strobe` then stays high without a gap through the last beat's `beat_rdy`, and `beat_rdy` is never high without `strobe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the wait-code register |
| cfg_code | input | 4 | Wait code to be written |
| mux_sel | input | 1 | 0 selects static-memory style, 1 selects multiplexed style |
| rd_req | input | 1 | 1 for a read access, 0 for a write access |
| start | input | 1 | Access request, taken only while idle |
| beat_cnt | input | BEAT_W | Number of beats (0 is treated as 1) |
| strobe | output | 1 | High during the data phase of an access |
| beat_rdy | output | 1 | One-clock pulse on the last clock of each beat |
| done | output | 1 | One-clock pulse after the final beat |

## Verification
The assertions check the following on every clock: `beat_rdy` appears only under `strobe`; an accepted start always raises `strobe`; `done` is a lone one-clock pulse that follows a beat end, never overlaps `strobe` and is never followed by a new strobe; and no beat runs past the longest legal wait. The exact wait for each code, style and direction cannot be seen from single clocks, and neither can the capture of settings at start or the treatment of a zero beat count. The bench shows these with full sweeps of all sixteen codes in both styles and both directions. It measures every beat length against a table built from the requirements.

// File: rtl/bws_pkg.sv
package bws_pkg;

  localparam int CODE_W = 4;
  localparam int WAIT_W = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } bws_state_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              mux;
    logic              rd;
  } bws_cfg_t;

  // Static-memory wait count: linear to nine, then steps of two, then four.
  function automatic logic [WAIT_W-1:0] static_waits(input logic [CODE_W-1:0] c);
    logic [WAIT_W:0] wide;
    if (c < CODE_W'(10))
      wide = (WAIT_W+1)'(c);
    else if (c < CODE_W'(14))
      wide = (WAIT_W+1)'({c, 1'b0}) - (WAIT_W+1)'(9);
    else
      wide = (WAIT_W+1)'({c, 2'b00}) - (WAIT_W+1)'(35);
    return wide[WAIT_W-1:0];
  endfunction

endpackage

// File: rtl/bws_code_reg.sv
module bws_code_reg
  import bws_pkg::*;
#(
  parameter logic [CODE_W-1:0] RESET_CODE = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      code <= RESET_CODE;
    else if (we)
      code <= wdata;
  end

endmodule

// File: rtl/bws_wait_map.sv
module bws_wait_map
  import bws_pkg::*;
(
  input  bws_cfg_t          cfg,
  input  logic              first_beat,
  output logic [WAIT_W-1:0] waits
);

  logic [WAIT_W-1:0] mux_first;
  logic [WAIT_W-1:0] mux_later;

  always_comb begin
    // Multiplexed first beat: low field, with the read-only extra wait at 00.
    if (cfg.code[1:0] == 2'b00)
      mux_first = WAIT_W'(cfg.rd);
    else
      mux_first = WAIT_W'(cfg.code[1:0]);
    mux_later = WAIT_W'(cfg.code[2]);

    if (!cfg.mux)
      waits = static_waits(cfg.code);
    else if (first_beat)
      waits = mux_first;
    else
      waits = mux_later;
  end

endmodule

// File: rtl/bws_beat_seq.sv
module bws_beat_seq
  import bws_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  bws_cfg_t          live_cfg,
  input  logic [BEAT_W-1:0] beats,
  input  logic [WAIT_W-1:0] first_waits,
  input  logic [WAIT_W-1:0] later_waits,
  output bws_cfg_t          held_cfg,
  output logic              strobe,
  output logic              beat_rdy,
  output logic              done
);

  bws_state_e        state;
  logic [WAIT_W-1:0] wcnt;
  logic [BEAT_W-1:0] left;
  logic              beat_end;

  assign strobe   = (state == ST_BEAT);
  assign beat_end = strobe && (wcnt == '0);
  assign beat_rdy = beat_end;
  assign done     = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wcnt     <= '0;
      left     <= '0;
      held_cfg <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            held_cfg <= live_cfg;
            wcnt     <= first_waits;
            left     <= (beats == '0) ? '0 : beats - BEAT_W'(1);
            state    <= ST_BEAT;
          end
        end
        ST_BEAT: begin
          if (!beat_end) begin
            wcnt <= wcnt - WAIT_W'(1);
          end else if (left == '0) begin
            state <= ST_DONE;
          end else begin
            left <= left - BEAT_W'(1);
            wcnt <= later_waits;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int BEAT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_code,
  input  logic              mux_sel,
  input  logic              rd_req,
  input  logic              start,
  input  logic [BEAT_W-1:0] beat_cnt,
  output logic              strobe,
  output logic              beat_rdy,
  output logic              done
);

  logic [CODE_W-1:0] code_q;
  bws_cfg_t          live_cfg;
  bws_cfg_t          held_cfg;
  logic [WAIT_W-1:0] first_waits;
  logic [WAIT_W-1:0] later_waits;

  bws_code_reg #(.RESET_CODE('1)) u_code (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_code),
    .code  (code_q)
  );

  assign live_cfg = '{code: code_q, mux: mux_sel, rd: rd_req};

  // First-beat count comes from the live settings so it loads at the start edge;
  // later beats read the settings captured at that edge.
  bws_wait_map u_map_first (
    .cfg        (live_cfg),
    .first_beat (1'b1),
    .waits      (first_waits)
  );

  bws_wait_map u_map_later (
    .cfg        (held_cfg),
    .first_beat (1'b0),
    .waits      (later_waits)
  );

  bws_beat_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .live_cfg    (live_cfg),
    .beats       (beat_cnt),
    .first_waits (first_waits),
    .later_waits (later_waits),
    .held_cfg    (held_cfg),
    .strobe      (strobe),
    .beat_rdy    (beat_rdy),
    .done        (done)
  );

endmodule

// File: rtl/bws_checker.sv
module bws_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic strobe,
  input logic beat_rdy,
  input logic done
);

  localparam int MAX_WAIT = 25;

  logic [5:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_len <= '0;
    else if (!strobe || beat_rdy)
      run_len <= '0;
    else
      run_len <= run_len + 6'd1;
  end

  a_r12_rdy_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    beat_rdy |-> strobe);

  a_r12_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !strobe && !done) |=> strobe);

  a_r9_done_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(beat_rdy) && !strobe));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_no_restart_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !strobe);

  a_r3_beat_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (run_len <= 6'(MAX_WAIT)));

endmodule

bind bus_wait_seq bws_checker u_bws_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .strobe   (strobe),
  .beat_rdy (beat_rdy),
  .done     (done)
);

// File: tb/tb_bus_wait_seq.sv
module tb_bus_wait_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_code = 4'd0;
  logic       mux_sel = 1'b0;
  logic       rd_req = 1'b0;
  logic       start = 1'b0;
  logic [3:0] beat_cnt = 4'd0;
  logic       strobe;
  logic       beat_rdy;
  logic       done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int static_tbl [16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 13, 15, 17, 21, 25};

  always #5 clk = ~clk;

  bus_wait_seq #(.BEAT_W(4)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_code (cfg_code),
    .mux_sel  (mux_sel),
    .rd_req   (rd_req),
    .start    (start),
    .beat_cnt (beat_cnt),
    .strobe   (strobe),
    .beat_rdy (beat_rdy),
    .done     (done)
  );

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int exp_waits(input logic [3:0] code, input bit mux, input bit rd, input int b);
    if (!mux) return static_tbl[code];
    if (b > 0) return int'(code[2]);
    if (code[1:0] == 2'b00) return rd ? 1 : 0;
    return int'(code[1:0]);
  endfunction

  // One access; the bench sits at a negedge on entry and on exit.
  task automatic run_acc(input logic [3:0] code, input bit load, input bit mux, input bit rd,
                         input int nb, input bit same_w, input bit mid_w, input bit poke,
                         input logic [3:0] other, input string req_first, input string req_later);
    int n;
    int len;
    if (load) begin
      cfg_we = 1'b1; cfg_code = code;
      @(negedge clk);
      cfg_we = 1'b0;
    end
    mux_sel = mux; rd_req = rd; beat_cnt = 4'(nb); start = 1'b1;
    if (same_w) begin cfg_we = 1'b1; cfg_code = other; end
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    n = (nb == 0) ? 1 : nb;
    for (int b = 0; b < n; b++) begin
      len = 0;
      for (int c = 0; c < 40; c++) begin
        if (mid_w && b == 0 && c == 0) begin cfg_we = 1'b1; cfg_code = other; end
        else cfg_we = 1'b0;
        if (poke && b == 0 && c == 1) begin
          start = 1'b1; beat_cnt = 4'd9; mux_sel = ~mux; rd_req = ~rd;
        end else start = 1'b0;
        chk("R12", "strobe in beat", int'(strobe), 1);
        len++;
        if (beat_rdy) break;
        @(negedge clk);
      end
      chk((b == 0) ? req_first : req_later, $sformatf("beat %0d length code=%0d mux=%0d rd=%0d", b, code, mux, rd),
          len, exp_waits(code, mux, rd, b) + 1);
      @(negedge clk);
      cfg_we = 1'b0; start = 1'b0;
    end
    chk("R9", "done after last beat", int'(done), 1);
    chk("R9", "strobe low in done", int'(strobe), 0);
    if (poke) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(poke ? "R10" : "R9", "idle after done strobe", int'(strobe), 0);
    chk("R9", "done single clock", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "strobe in reset", int'(strobe), 0);
    chk("R1", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "strobe after reset", int'(strobe), 0);
    chk("R1", "beat_rdy after reset", int'(beat_rdy), 0);
    chk("R1", "done after reset", int'(done), 0);
    // Default code without any write: 25 waits.
    run_acc(4'hF, 1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b0, 1'b0, 4'd0, "R1", "R1");

    // Static-memory sweep, all codes, both directions, two beats.
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 2; r++) begin
        run_acc(4'(c), 1'b1, 1'b0, r[0], 2, 1'b0, 1'b0, 1'b0, 4'd0,
                (c < 10) ? "R2" : "R3", "R4");
      end
    end

    // Multiplexed sweep, all codes (bit 3 must not matter), three beats.
    for (int c = 0; c < 16; c++) begin
      for (int r = 0; r < 2; r++) begin
        run_acc(4'(c), 1'b1, 1'b1, r[0], 3, 1'b0, 1'b0, 1'b0, 4'd0,
                (c >= 8) ? "R7" : "R5", (c >= 8) ? "R7" : "R6");
      end
    end

    // Zero beat count in both styles.
    run_acc(4'd3, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 4'd0, "R11", "R11");
    run_acc(4'd6, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0, 4'd0, "R11", "R11");

    // Write during the access; the new code applies next time.
    run_acc(4'd6, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b1, 1'b0, 4'd0, "R8", "R8");
    run_acc(4'd0, 1'b0, 1'b0, 1'b1, 1, 1'b0, 1'b0, 1'b0, 4'd0, "R8", "R8");

    // Write at the same edge as start.
    run_acc(4'd5, 1'b1, 1'b0, 1'b0, 1, 1'b1, 1'b0, 1'b0, 4'd12, "R8", "R8");
    run_acc(4'd12, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b0, 1'b0, 4'd0, "R8", "R8");

    // Start requests during the data phase and during done are ignored.
    run_acc(4'd9, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b0, 1'b1, 4'd0, "R10", "R10");
    run_acc(4'd7, 1'b1, 1'b1, 1'b0, 2, 1'b0, 1'b0, 1'b1, 4'd0, "R10", "R10");
    repeat (2) begin
      @(negedge clk);
      chk("R10", "no access after ignored start", int'(strobe), 0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule